// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple synchronous request bus and an external asynchronous static RAM of 256K words by 16 bits. A requester presents a strobe, a read/write flag, an 18-bit word address, 16 bits of write data and two byte-lane enables. The controller turns each accepted request into a correctly sequenced memory cycle on the active-low chip-select, write-strobe, read-strobe and per-lane select pins. For reads it returns the captured word with a one-cycle valid pulse.

The memory's data pins are split here into an outbound bus, an inbound bus and a driver-enable signal. The pad ring joins them into the shared bidirectional bus. The access window is a count of system clocks. It is derived from the clock period and the memory access time, so the same RTL meets the 10 ns budget at any clock rate.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever `ready_o` is high, the chip-select, write-strobe, read-strobe and both lane selects are all high, and the data drivers are disabled.
- R2: A write drives chip-select and write-strobe low. Lane enable bit 0 selects data bits 7:0 through `mem_lb_no`, and bit 1 selects bits 15:8 through `mem_ub_no`. Only the enabled lanes of the addressed word change.
- R3: The access window ACC is ceil(ACCESS_PS / CLK_PS) + 1 clocks. Write-strobe stays low for exactly ACC clocks. Chip-select, address and lane selects are valid one clock before write-strobe falls, and are unchanged one clock after it rises.
- R4: The data drivers are enabled only while read-strobe is high, and only in the write-strobe-low clocks and the hold clock that follows them.
- R5: A read holds chip-select and read-strobe low, write-strobe high and the address steady for ACC clocks, then captures the data. Disabled lanes read back as zero.
- R6: `rvalid_o` is a single-clock pulse, and `rdata_o` is valid while it is high.
- R7: `ready_o` drops in the clock after a request is accepted. It stays low for ACC clocks on a read and ACC+2 clocks on a write. Any request made while `ready_o` is low is ignored.
- R8: A request with both lane enables clear starts no memory cycle and leaves `ready_o` high. If it is a read, it pulses `rvalid_o` in the next clock with zero data.
- R9: Read-strobe and write-strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Lane enables, bit 0 = low byte, bit 1 = high byte |
| ready_o | output | 1 | Controller idle, able to take a request |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 16 | Captured read data |
| mem_ce_no | output | 1 | Memory chip-select, active low |
| mem_we_no | output | 1 | Memory write-strobe, active low |
| mem_oe_no | output | 1 | Memory read-strobe, active low |
| mem_lb_no | output | 1 | Low-byte lane select, active low |
| mem_ub_no | output | 1 | High-byte lane select, active low |
| mem_addr_o | output | 18 | Memory word address |
| mem_dq_o | output | 16 | Outbound data to the pad drivers |
| mem_dq_oe_o | output | 1 | Pad driver enable |
| mem_dq_i | input | 16 | Inbound data from the pads |

## Verification
The bench builds the controller with CLK_PS = 5000 and ACCESS_PS = 10000, which gives an access window of three clocks. At that setting the memory model needs two clocks of stable address before it returns real data, so the one clock of margin is exercised directly. Any shortening of the window would capture the filler byte the model drives before then. With a window of three, a competing request can also be raised and dropped while the controller is busy, and it must leave no trace in memory. The model drives a filler pattern on every lane that is not selected, which shows whether disabled lanes are masked to zero.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WHLD = 3'd3,
    ST_RACC = 3'd4
  } sram_st_e;

  // access window in clocks: ceil(access/period) plus one margin clock
  function automatic int unsigned acc_cycles(input int unsigned access_ps,
                                             input int unsigned clk_ps);
    return (access_ps + clk_ps - 1) / clk_ps + 1;
  endfunction

endpackage

// File: rtl/sram_acc_timer.sv
module sram_acc_timer #(
  parameter int unsigned CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
  parameter int unsigned LANES = 2
) (
  input  logic                 act_i,
  input  logic [LANES-1:0]     be_i,
  input  logic [LANES*8-1:0]   dq_i,
  output logic [LANES-1:0]     lane_n_o,
  output logic [LANES*8-1:0]   rd_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n_o[g]     = ~(act_i & be_i[g]);
    assign rd_o[g*8 +: 8]  = be_i[g] ? dq_i[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 18,
  parameter int unsigned DW        = 16,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned ACCESS_PS = 10000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [1:0]      be_i,
  output logic            ready_o,
  output logic            rvalid_o,
  output logic [DW-1:0]   rdata_o,
  output logic            mem_ce_no,
  output logic            mem_we_no,
  output logic            mem_oe_no,
  output logic            mem_lb_no,
  output logic            mem_ub_no,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe_o,
  input  logic [DW-1:0]   mem_dq_i
);
  localparam int unsigned LANES   = DW / 8;
  localparam int unsigned ACC_CYC = acc_cycles(ACCESS_PS, CLK_PS);

  sram_st_e            st_q, st_d;
  logic [AW-1:0]       addr_q;
  logic [DW-1:0]       wdata_q;
  logic [LANES-1:0]    be_q;
  logic                rvalid_q;
  logic [DW-1:0]       rdata_q;
  logic                accept, empty, t_load, t_done;
  logic [LANES-1:0]    lane_n;
  logic [DW-1:0]       rd_masked;

  assign accept = req_i && (st_q == ST_IDLE);
  assign empty  = (be_i == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept && !empty) st_d = we_i ? ST_WSET : ST_RACC;
      ST_WSET: st_d = ST_WPUL;
      ST_WPUL: if (t_done) st_d = ST_WHLD;
      ST_WHLD: st_d = ST_IDLE;
      ST_RACC: if (t_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign t_load = (st_q == ST_WSET) || (st_q == ST_IDLE && st_d == ST_RACC);

  sram_acc_timer #(.CYC(ACC_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .done_o (t_done)
  );

  sram_lane_mask #(.LANES(LANES)) u_lanes (
    .act_i    (st_q != ST_IDLE),
    .be_i     (be_q),
    .dq_i     (mem_dq_i),
    .lane_n_o (lane_n),
    .rd_o     (rd_masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      st_q     <= st_d;
      rvalid_q <= 1'b0;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
        if (!we_i && empty) begin
          rvalid_q <= 1'b1;
          rdata_q  <= '0;
        end
      end
      if (st_q == ST_RACC && t_done) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_masked;
      end
    end
  end

  assign ready_o     = (st_q == ST_IDLE);
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign mem_ce_no   = (st_q == ST_IDLE);
  assign mem_we_no   = (st_q != ST_WPUL);
  assign mem_oe_no   = (st_q != ST_RACC);
  assign mem_lb_no   = lane_n[0];
  assign mem_ub_no   = lane_n[LANES-1];
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = (st_q == ST_WPUL) || (st_q == ST_WHLD);
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned AW        = 18,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned ACCESS_PS = 10000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic          mem_ce_no,
  input logic          mem_we_no,
  input logic          mem_oe_no,
  input logic          mem_lb_no,
  input logic          mem_ub_no,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_dq_oe_o
);
  localparam int unsigned ACC = sram_ctrl_pkg::acc_cycles(ACCESS_PS, CLK_PS);

  int unsigned wlo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wlo_cnt <= 0;
    else if (!mem_we_no) wlo_cnt <= wlo_cnt + 1;
    else                 wlo_cnt <= 0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce_no && mem_we_no && mem_oe_no && mem_lb_no && mem_ub_no && !mem_dq_oe_o));

  assert_we_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> ($past(!mem_ce_no) && $stable(mem_addr_o) && $stable({mem_ub_no, mem_lb_no})));

  assert_we_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (!mem_ce_no && $stable(mem_addr_o) && $stable({mem_ub_no, mem_lb_no})));

  assert_we_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wlo_cnt <= ACC);

  assert_no_contention_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  assert_rvalid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_busy_after_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(req_i));

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .AW(AW), .CLK_PS(CLK_PS), .ACCESS_PS(ACCESS_PS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_ce_no   (mem_ce_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_lb_no   (mem_lb_no),
  .mem_ub_no   (mem_ub_no),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  localparam int CLK_PS    = 5000;
  localparam int ACCESS_PS = 10000;
  localparam int HALF      = 5;
  localparam int NEED      = (ACCESS_PS + CLK_PS - 1) / CLK_PS;
  localparam int ACC       = NEED + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready, rvalid;
  logic [15:0] rdata;
  logic        ce_n, we_n, oe_n, lb_n, ub_n, dq_oe;
  logic [17:0] maddr;
  logic [15:0] dq_out, dq_in;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #HALF clk = ~clk;

  sram_lane_ctrl #(.CLK_PS(CLK_PS), .ACCESS_PS(ACCESS_PS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .rvalid_o(rvalid),
    .rdata_o(rdata), .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_lb_no(lb_n), .mem_ub_no(ub_n), .mem_addr_o(maddr), .mem_dq_o(dq_out),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model (pin side) and reference model (request side)
  logic [15:0] mem_m [int];
  logic [15:0] ref_m [int];

  function automatic logic [15:0] mrd(input int a);
    return mem_m.exists(a) ? mem_m[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] rrd(input int a);
    return ref_m.exists(a) ? ref_m[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  int rd_age = 0;
  logic [17:0] last_addr = '0;
  wire rd_act = !ce_n && !oe_n && we_n;

  always @(posedge clk) begin
    last_addr <= maddr;
    rd_age    <= (rd_act && maddr == last_addr) ? rd_age + 1 : (rd_act ? 1 : 0);
    if (!ce_n && !we_n && rst_n) begin
      mem_m[int'(maddr)] = merge(mrd(int'(maddr)), dq_out, {~ub_n, ~lb_n});
    end
  end

  always_comb begin
    logic [15:0] v;
    v = mrd(int'(maddr));
    dq_in = 16'hA5A5;
    if (rd_act && rd_age >= NEED) begin
      if (!lb_n) dq_in[7:0]  = v[7:0];
      if (!ub_n) dq_in[15:8] = v[15:8];
    end
  end

  // pin-side monitor on negative edges
  logic p_ce = 1, p_we = 1, p_lb = 1, p_ub = 1;
  logic [17:0] p_addr = '0;
  int wlen = 0;
  always @(negedge clk) if (rst_n) begin
    if (dq_oe && !oe_n) chk(0, "R4 drivers on while read-strobe low", 1, 0);
    if (!oe_n && !we_n) chk(0, "R9 both strobes low", 1, 0);
    if (p_we && !we_n)
      chk(!p_ce && p_addr == maddr && p_lb == lb_n && p_ub == ub_n,
          "R3 setup before write-strobe", {p_ce, p_lb, p_ub}, 0);
    if (!p_we && we_n) begin
      chk(wlen == ACC, "R3 write-strobe width", wlen, ACC);
      chk(!ce_n && p_addr == maddr && p_lb == lb_n && p_ub == ub_n,
          "R3 hold after write-strobe", ce_n, 0);
      wlen = 0;
    end
    if (!we_n) wlen++;
    p_ce = ce_n; p_we = we_n; p_lb = lb_n; p_ub = ub_n; p_addr = maddr;
  end

  // issue one request; spy injects a competing write while busy (R7)
  task automatic xfer(input bit w, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] m, input bit spy);
    int busy;
    logic [15:0] exp;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; be = m;
    exp = rrd(int'(a)) & {{8{m[1]}}, {8{m[0]}}};
    if (w) ref_m[int'(a)] = merge(rrd(int'(a)), d, m);
    @(negedge clk);
    req = 0;
    busy = 0;
    while (!ready && busy < 20) begin
      if (spy && busy == 0) begin
        req = 1; we = 1; addr = 18'h2AAAA; wdata = 16'hDEAD; be = 2'b11;
      end
      if (spy && busy == 1) req = 0;
      busy++;
      @(negedge clk);
    end
    if (m == 2'b00) chk(busy == 0, "R8 empty mask keeps ready high", busy, 0);
    else if (w)     chk(busy == ACC + 2, "R7 write busy length", busy, ACC + 2);
    else            chk(busy == ACC, "R7 read busy length", busy, ACC);
    if (!w) begin
      chk(rvalid == 1'b1, "R6 rvalid with completion", rvalid, 1);
      chk(rdata == exp, (m == 2'b00) ? "R8 empty read zero" : "R5 read data", rdata, exp);
      @(negedge clk);
      chk(rvalid == 1'b0, "R6 rvalid single pulse", rvalid, 0);
    end else begin
      chk(rvalid == 1'b0, "R2 no rvalid on write", rvalid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(ready && ce_n && we_n && oe_n && lb_n && ub_n && !dq_oe,
        "R1 reset state", {ready, ce_n, we_n, oe_n, lb_n, ub_n, dq_oe}, 7'b1111110);
    rst_n = 1;
    @(negedge clk);
    chk(ready && ce_n && we_n && oe_n && lb_n && ub_n && !dq_oe,
        "R1 idle after reset", {ready, ce_n, we_n, oe_n}, 4'b1111);
    // directed lanes (R2, R5)
    xfer(1, 18'h00010, 16'h1234, 2'b11, 0);
    xfer(1, 18'h00010, 16'hAB00, 2'b10, 0);
    xfer(0, 18'h00010, 16'h0,    2'b11, 0);
    xfer(1, 18'h00010, 16'h00CD, 2'b01, 0);
    xfer(0, 18'h00010, 16'h0,    2'b01, 0);
    xfer(0, 18'h00010, 16'h0,    2'b10, 0);
    xfer(1, 18'h3FFFF, 16'hFFFF, 2'b11, 0);
    xfer(0, 18'h3FFFF, 16'h0,    2'b11, 0);
    // empty masks (R8)
    xfer(1, 18'h00010, 16'h7777, 2'b00, 0);
    xfer(0, 18'h00010, 16'h0,    2'b00, 0);
    xfer(0, 18'h00010, 16'h0,    2'b11, 0);
    // request while busy is ignored (R7)
    xfer(0, 18'h00010, 16'h0, 2'b11, 1);
    xfer(0, 18'h2AAAA, 16'h0, 2'b11, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [17:0] ra;
      ra = ($urandom % 4 == 0) ? 18'($urandom) : 18'($urandom % 24);
      xfer(1'($urandom), ra, 16'($urandom), 2'($urandom), 0);
    end
    // back-to-back read then write turnaround (R4)
    xfer(0, 18'h00005, 16'h0,    2'b11, 0);
    xfer(1, 18'h00005, 16'h5A5A, 2'b11, 0);
    xfer(0, 18'h00005, 16'h0,    2'b11, 0);
    @(negedge clk);
    chk(ce_n && we_n && oe_n && lb_n && ub_n, "R1 idle at end", ce_n, 1);
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule